// File: doc/BRIEF.md
# ADC Calibration Mode Sequencer

This block is the digital sequencing logic that runs system calibration inside a sigma-delta converter. Software writes a setup word with a two-bit mode field and a gain field. An upper mode bit of 0 selects normal conversion. Code 2'b10 starts a zero-scale step and code 2'b11 starts a full-scale step. A step runs for a fixed number of output-rate periods, captures the conversion result into the offset or gain coefficient register, and then clears the mode field by itself.

The active-low data-ready flag goes high once a step has been commanded. It goes low again only after one further normal conversion has loaded the data register. Software either polls the mode bits for completion or waits for the flag. The modulator and the decimation filter are outside the block. The block sees them only as a modulator-cycle enable, an output-rate tick and a conversion sample.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset, mode_o is 2'b00, rdy_n_o is 1, data_o is 0, offset_o is 0 and gain_o is unity, which is 16'h8000 (unsigned, 15 fraction bits).
- R2: Writing mode 2'b10 starts a zero-scale step and 2'b11 starts a full-scale step. mode_o reads back that code from the cycle after the write until the step ends. mode_o never shows 2'b01. Codes 2'b00 and 2'b01 both mean normal conversion and read back as 2'b00.
- R3: A step counts STEP_TICKS (default 3) rate ticks after the write cycle; a tick in the write cycle itself does not count. On the last counted tick the sample is captured, and mode_o is 2'b00 from the next cycle.
- R4: During a step or its trailing conversion, rdy_n_o goes high in the cycle after the first mod_en_i pulse that follows the command. Before that pulse it keeps its old value.
- R5: After a completed step, rdy_n_o returns low only on the next rate tick (the fourth tick after the command by default), and that tick loads sample_i into data_o.
- R6: A zero-scale step writes only offset_o and a full-scale step writes only gain_o. Repeating one step leaves the other coefficient unchanged.
- R7: A write with the upper mode bit at 0 during a step aborts it. mode_o becomes 2'b00, both coefficients keep their values, and the next tick is a normal conversion.
- R8: A calibration-code write during a step restarts the count from zero with the new code.
- R9: In normal mode, every rate tick loads sample_i into data_o and drives rdy_n_o low. A mod_en_i pulse then has no effect on rdy_n_o.
- R10: Every setup write loads pga_i into pga_o. pga_o holds through the step, so both steps run at the selected gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| wr_en_i | input | 1 | setup register write strobe |
| wr_mode_i | input | 2 | mode field of the write data |
| pga_i | input | 3 | gain field of the write data |
| mod_en_i | input | 1 | one pulse per modulator cycle |
| rate_tick_i | input | 1 | one pulse per output-rate period |
| sample_i | input | 16 | conversion result valid with the tick |
| mode_o | output | 2 | mode field read-back |
| pga_o | output | 3 | gain field read-back |
| rdy_n_o | output | 1 | data-ready, active low |
| data_o | output | 16 | data register |
| offset_o | output | 16 | zero-scale coefficient |
| gain_o | output | 16 | full-scale coefficient |

## Verification
The bench counts rate ticks precisely around each step. A design with an off-by-one counter would clear the mode bits a tick early or late, or would drop the flag on the third tick instead of the fourth. The bench holds back the modulator pulse after a command to catch a flag that rises straight from the write. It also aborts a step and restarts a step mid-count, which exposes a design that captures a coefficient on abort or keeps counting from the old step. Finally, it lands a command in the same cycle as a tick and repeats each step type, which exposes a design that counts the command's own tick or overwrites the wrong coefficient.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_CAL  = 2'd1,
    ST_POST = 2'd2
  } step_e;

  localparam logic [1:0] MODE_NORM = 2'b00;
endpackage

// File: rtl/adc_cal_step_ctrl.sv
module adc_cal_step_ctrl
  import adc_cal_pkg::*;
#(
  parameter int STEP_TICKS = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_mode_i,
  input  logic       rate_tick_i,
  output logic [1:0] mode_o,
  output logic       busy_o,
  output logic [1:0] cap_o,
  output logic       conv_o
);
  localparam int CNT_W = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_TICKS - 1);

  step_e          state_q;
  logic [CNT_W-1:0] cnt_q;
  logic           fs_q;
  logic           wr_cal, wr_abort, last_tick;

  always_comb begin
    wr_cal    = wr_en_i & wr_mode_i[1];
    wr_abort  = wr_en_i & ~wr_mode_i[1] & (state_q == ST_CAL);
    // any write during a step overrides its tick
    last_tick = rate_tick_i & ~wr_en_i & (state_q == ST_CAL) & (cnt_q == CNT_LAST);
    cap_o     = {last_tick & fs_q, last_tick & ~fs_q};
    conv_o    = rate_tick_i & ~wr_cal & ((state_q == ST_NORM) | (state_q == ST_POST));
    busy_o    = (state_q != ST_NORM);
    mode_o    = (state_q == ST_CAL) ? {1'b1, fs_q} : MODE_NORM;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_NORM;
      cnt_q   <= '0;
      fs_q    <= 1'b0;
    end else if (wr_cal) begin
      state_q <= ST_CAL;
      cnt_q   <= '0;
      fs_q    <= wr_mode_i[0];
    end else if (wr_abort) begin
      state_q <= ST_NORM;
      cnt_q   <= '0;
    end else if (rate_tick_i) begin
      unique case (state_q)
        ST_CAL: begin
          if (cnt_q == CNT_LAST) begin
            state_q <= ST_POST;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_POST: state_q <= ST_NORM;
        default: state_q <= ST_NORM;
      endcase
    end
  end
endmodule

// File: rtl/adc_cal_coef_regs.sv
module adc_cal_coef_regs #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   cap_i,
  input  logic [W-1:0] sample_i,
  output logic [W-1:0] offset_o,
  output logic [W-1:0] gain_o
);
  localparam logic [W-1:0] UNITY = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] coef_q [2];

  // entry 0: offset (resets to zero), entry 1: gain (resets to unity)
  for (genvar i = 0; i < 2; i++) begin : g_coef
    localparam logic [W-1:0] RST_VAL = (i == 0) ? '0 : UNITY;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       coef_q[i] <= RST_VAL;
      else if (cap_i[i]) coef_q[i] <= sample_i;
    end
  end

  assign offset_o = coef_q[0];
  assign gain_o   = coef_q[1];
endmodule

// File: rtl/adc_cal_rdy.sv
module adc_cal_rdy #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         conv_i,
  input  logic         busy_i,
  input  logic         mod_en_i,
  input  logic [W-1:0] sample_i,
  output logic         rdy_n_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_n_o <= 1'b1;
      data_o  <= '0;
    end else if (conv_i) begin
      rdy_n_o <= 1'b0;
      data_o  <= sample_i;
    end else if (busy_i && mod_en_i) begin
      rdy_n_o <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq #(
  parameter int W          = 16,
  parameter int PGA_W      = 3,
  parameter int STEP_TICKS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_mode_i,
  input  logic [PGA_W-1:0] pga_i,
  input  logic             mod_en_i,
  input  logic             rate_tick_i,
  input  logic [W-1:0]     sample_i,
  output logic [1:0]       mode_o,
  output logic [PGA_W-1:0] pga_o,
  output logic             rdy_n_o,
  output logic [W-1:0]     data_o,
  output logic [W-1:0]     offset_o,
  output logic [W-1:0]     gain_o
);
  logic       busy, conv;
  logic [1:0] cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pga_o <= '0;
    else if (wr_en_i) pga_o <= pga_i;
  end

  adc_cal_step_ctrl #(.STEP_TICKS(STEP_TICKS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_mode_i  (wr_mode_i),
    .rate_tick_i(rate_tick_i),
    .mode_o     (mode_o),
    .busy_o     (busy),
    .cap_o      (cap),
    .conv_o     (conv)
  );

  adc_cal_coef_regs #(.W(W)) u_coef (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .sample_i(sample_i),
    .offset_o(offset_o),
    .gain_o  (gain_o)
  );

  adc_cal_rdy #(.W(W)) u_rdy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .conv_i  (conv),
    .busy_i  (busy),
    .mod_en_i(mod_en_i),
    .sample_i(sample_i),
    .rdy_n_o (rdy_n_o),
    .data_o  (data_o)
  );
endmodule

// File: rtl/adc_cal_seq_chk.sv
module adc_cal_seq_chk #(
  parameter int W     = 16,
  parameter int PGA_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_mode_i,
  input logic [PGA_W-1:0] pga_i,
  input logic             mod_en_i,
  input logic             rate_tick_i,
  input logic [1:0]       mode_o,
  input logic [PGA_W-1:0] pga_o,
  input logic             rdy_n_o,
  input logic [W-1:0]     offset_o,
  input logic [W-1:0]     gain_o
);
  p_mode_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b01);

  p_cal_readback_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_mode_i[1]) |=> (mode_o == $past(wr_mode_i)));

  p_rdy_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_en_i && mode_o != 2'b00) |=> rdy_n_o);

  p_rdy_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_n_o) |-> $past(rate_tick_i));

  p_offset_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (offset_o != $past(offset_o)) |->
      ($past(mode_o) == 2'b10 && $past(rate_tick_i) && !$past(wr_en_i)));

  p_gain_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_o != $past(gain_o)) |->
      ($past(mode_o) == 2'b11 && $past(rate_tick_i) && !$past(wr_en_i)));

  p_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_mode_i[1]) |=> (mode_o == 2'b00));

  p_pga_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (pga_o == $past(pga_i)));

  p_pga_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(pga_o));
endmodule

bind adc_cal_seq adc_cal_seq_chk #(.W(W), .PGA_W(PGA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_mode_i  (wr_mode_i),
  .pga_i      (pga_i),
  .mod_en_i   (mod_en_i),
  .rate_tick_i(rate_tick_i),
  .mode_o     (mode_o),
  .pga_o      (pga_o),
  .rdy_n_o    (rdy_n_o),
  .offset_o   (offset_o),
  .gain_o     (gain_o)
);

// File: tb/adc_cal_seq_bench.sv
module adc_cal_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_mode = 2'b00;
  logic [2:0]  pga = 3'd0;
  logic        mod_en = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] sample = 16'h0;
  logic [1:0]  mode;
  logic [2:0]  pga_rb;
  logic        rdy_n;
  logic [15:0] data, offset, gain;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_off, exp_gain;

  always #10 clk = ~clk;

  adc_cal_seq u_adc_cal_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_mode_i(wr_mode),
    .pga_i(pga), .mod_en_i(mod_en), .rate_tick_i(tick), .sample_i(sample),
    .mode_o(mode), .pga_o(pga_rb), .rdy_n_o(rdy_n), .data_o(data),
    .offset_o(offset), .gain_o(gain)
  );

  typedef struct packed {
    logic [1:0]  code;
    logic [2:0]  gsel;
    logic [15:0] fin;
    logic [15:0] post;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{code: 2'b10, gsel: 3'd1, fin: 16'h0123, post: 16'hA001},
    '{code: 2'b11, gsel: 3'd4, fin: 16'hF00D, post: 16'hA002},
    '{code: 2'b10, gsel: 3'd7, fin: 16'h7E57, post: 16'hA003},
    '{code: 2'b11, gsel: 3'd2, fin: 16'h4321, post: 16'hA004}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_tick(input logic [15:0] s);
    @(negedge clk); tick = 1'b1; sample = s;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] m, input logic [2:0] g);
    @(negedge clk); wr_en = 1'b1; wr_mode = m; pga = g;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_mod();
    @(negedge clk); mod_en = 1'b1;
    @(negedge clk); mod_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R3 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", 32'(mode), 32'h0);
    chk("R1 rdy_n", 32'(rdy_n), 32'h1);
    chk("R1 data", 32'(data), 32'h0);
    chk("R1 offset", 32'(offset), 32'h0);
    chk("R1 gain", 32'(gain), 32'h8000);
    rst_n = 1'b1;
    exp_off = 16'h0; exp_gain = 16'h8000;

    // R9 normal conversion
    do_tick(16'h1234);
    chk("R9 rdy_n", 32'(rdy_n), 32'h0);
    chk("R9 data", 32'(data), 32'h1234);
    do_mod();
    chk("R9 mod no effect", 32'(rdy_n), 32'h0);

    // table of full steps
    for (int i = 0; i < 4; i++) begin
      do_write(VECS[i].code, VECS[i].gsel);
      chk("R2 readback", 32'(mode), 32'(VECS[i].code));
      chk("R10 pga", 32'(pga_rb), 32'(VECS[i].gsel));
      chk("R4 rdy before mod", 32'(rdy_n), 32'h0);
      do_mod();
      chk("R4 rdy after mod", 32'(rdy_n), 32'h1);
      do_tick(16'h1111);
      do_tick(16'h2222);
      chk("R3 mode held", 32'(mode), 32'(VECS[i].code));
      chk("R10 pga held", 32'(pga_rb), 32'(VECS[i].gsel));
      do_tick(VECS[i].fin);
      if (VECS[i].code[0]) exp_gain = VECS[i].fin; else exp_off = VECS[i].fin;
      chk("R3 mode cleared", 32'(mode), 32'h0);
      chk("R6 offset", 32'(offset), 32'(exp_off));
      chk("R6 gain", 32'(gain), 32'(exp_gain));
      chk("R5 rdy still high", 32'(rdy_n), 32'h1);
      do_tick(VECS[i].post);
      chk("R5 rdy low", 32'(rdy_n), 32'h0);
      chk("R5 data", 32'(data), 32'(VECS[i].post));
    end

    // R7 abort
    do_write(2'b10, 3'd3);
    do_mod();
    do_tick(16'hBAD0);
    do_write(2'b00, 3'd3);
    chk("R7 mode", 32'(mode), 32'h0);
    do_tick(16'hBAD1);
    chk("R7 offset kept", 32'(offset), 32'(exp_off));
    chk("R7 gain kept", 32'(gain), 32'(exp_gain));
    chk("R7 normal conv", 32'(data), 32'hBAD1);
    chk("R7 rdy low", 32'(rdy_n), 32'h0);

    // R2 code 01 is normal
    do_write(2'b01, 3'd5);
    chk("R2 code01 readback", 32'(mode), 32'h0);
    do_tick(16'h5151);
    chk("R2 code01 converts", 32'(data), 32'h5151);

    // R8 restart with new code
    do_write(2'b10, 3'd0);
    do_tick(16'hC001);
    do_tick(16'hC002);
    do_write(2'b11, 3'd0);
    chk("R8 new code", 32'(mode), 32'h3);
    do_tick(16'hC003);
    do_tick(16'hC004);
    chk("R8 count restarted", 32'(mode), 32'h3);
    chk("R8 offset kept", 32'(offset), 32'(exp_off));
    do_tick(16'hC005);
    exp_gain = 16'hC005;
    chk("R8 mode cleared", 32'(mode), 32'h0);
    chk("R8 gain", 32'(gain), 32'(exp_gain));
    do_tick(16'hC006);

    // R3 tick in the command cycle does not count
    @(negedge clk); wr_en = 1'b1; wr_mode = 2'b10; tick = 1'b1; sample = 16'hD000;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    do_tick(16'hD001);
    do_tick(16'hD002);
    chk("R3 same-cycle tick ignored", 32'(mode), 32'h2);
    do_tick(16'hD003);
    exp_off = 16'hD003;
    chk("R3 capture", 32'(offset), 32'(exp_off));
    chk("R3 cleared", 32'(mode), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule